// File: doc/BRIEF.md
# CRC-protected sensor frame transceiver

This block is an SPI master that exchanges fixed 32-bit frames with an inertial sensor. A user request supplies a 5-bit register address, a write flag and 16 bits of write data. The block packs these into a frame, appends an inverted CRC-8 and shifts the frame out in SPI mode 0. At the same time it captures the sensor's reply.

The sensor answers a command in the frame that follows it. For that reason every request runs two frames. The first frame carries the command itself. The second frame is a read of the same address, and its reply is the one kept. Between any two frames, including frames of different requests, chip select stays high for a minimum gap set in microseconds.

From the kept reply the block checks the checksum and decodes the 2-bit return-status field. It sign-extends the 16-bit payload and presents everything with a single-cycle done pulse.

Top module: `sensor_frame_xcvr`

## Requirements
- R1: The first frame of a request is {write, addr[4:0], 2'b00} in the top byte, then the 16-bit data field with its most significant byte first (the write data for a write, zero for a read), then the checksum byte; the 32 bits go out most significant bit first.
- R2: The checksum byte is the bitwise inverse of a CRC-8 with polynomial 0x1D, register preset to 0xFF, fed MSB-first with the three preceding bytes; for example a read of address 6 sends 0x180000E5 and a write of 0x0020 to address 13 sends 0xB4002098.
- R3: Every request issues exactly two frames; the second is a read of the same address with zero data (top byte {1'b0, addr, 2'b00}).
- R4: The result comes only from the second frame's reply; rsp_data is reply bits 23:8 sign-extended to OUT_W bits, and the first frame's reply has no effect on any output.
- R5: rsp_status equals reply bits 25:24, and rsp_dev_err is 1 exactly when that field is 3, independent of the checksum result.
- R6: rsp_crc_err is 1 exactly when reply bits 7:0 differ from the inverted CRC-8 (as in R2) of reply bits 31:8.
- R7: SPI mode 0: SCLK is low whenever cs_n is high, MOSI holds steady while SCLK is high, and MISO is sampled on the rising SCLK edge.
- R8: cs_n stays high for at least GAP_US microseconds of clock cycles (CLK_HZ/1e6 x GAP_US) between any two consecutive frames, also across requests.
- R9: req_ready is high only when idle; a request is taken when req_valid and req_ready are both high; each request gives exactly one rsp_done pulse of one cycle, and req_ready is low during that pulse.
- R10: After reset cs_n is 1, sclk is 0, rsp_done is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = register write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle pulse, result fields valid |
| rsp_data | output | OUT_W | Sign-extended reply payload |
| rsp_status | output | 2 | Reply return-status field |
| rsp_crc_err | output | 1 | Reply checksum mismatch |
| rsp_dev_err | output | 1 | Return status signals device error |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to sensor |
| miso | input | 1 | SPI data from sensor |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with CLK_HZ = 200 MHz and GAP_US = 10, so the real 2000-cycle chip-select gap is measured, both inside a request and between back-to-back requests. CLK_DIV = 2 keeps each frame short, so a dozen requests fit in the run. With these settings every status code and payload sign can be covered, along with corrupted checksums in both the ignored and the kept reply, and the address and data extremes.

// File: rtl/sensor_frame_xcvr.sv
module sensor_frame_xcvr #(
  parameter int CLK_HZ  = 200_000_000,
  parameter int GAP_US  = 10,
  parameter int CLK_DIV = 4,
  parameter int OUT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [4:0]       req_addr,
  input  logic [15:0]      req_wdata,
  output logic             rsp_done,
  output logic [OUT_W-1:0] rsp_data,
  output logic [1:0]       rsp_status,
  output logic             rsp_crc_err,
  output logic             rsp_dev_err,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int GAP_RAW    = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int GW         = $clog2(GAP_CYCLES + 1);
  localparam int DW         = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {IDLE, SHIFT, TAIL, GAP} state_t;

  function automatic logic [7:0] crc8(input logic [23:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] mk_frame(input logic w, input logic [4:0] a, input logic [15:0] d);
    logic [23:0] h;
    h = {w, a, 2'b00, d};
    return {h, crc8(h)};
  endfunction

  state_t        st;
  logic [DW-1:0] hcnt;
  logic [4:0]    bitn;
  logic [GW-1:0] gcnt;
  logic          second;
  logic [4:0]    addr_q;
  logic [31:0]   tx_sr, rx_sr;
  logic          half_end, crc_ok;

  assign req_ready = (st == IDLE);
  assign mosi      = tx_sr[31];
  assign half_end  = (hcnt == DW'(CLK_DIV - 1));
  assign crc_ok    = (crc8(rx_sr[31:8]) == rx_sr[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      hcnt        <= '0;
      bitn        <= '0;
      gcnt        <= '0;
      second      <= 1'b0;
      addr_q      <= '0;
      tx_sr       <= '0;
      rx_sr       <= '0;
      sclk        <= 1'b0;
      cs_n        <= 1'b1;
      rsp_done    <= 1'b0;
      rsp_data    <= '0;
      rsp_status  <= '0;
      rsp_crc_err <= 1'b0;
      rsp_dev_err <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          addr_q <= req_addr;
          tx_sr  <= mk_frame(req_write, req_addr, req_write ? req_wdata : 16'h0000);
          second <= 1'b0;
          cs_n   <= 1'b0;
          hcnt   <= '0;
          bitn   <= '0;
          st     <= SHIFT;
        end
        SHIFT: begin
          if (half_end) begin
            hcnt <= '0;
            if (!sclk) begin
              sclk  <= 1'b1;
              rx_sr <= {rx_sr[30:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bitn == 5'd31) st <= TAIL;
              else begin
                bitn  <= bitn + 5'd1;
                tx_sr <= {tx_sr[30:0], 1'b0};
              end
            end
          end else hcnt <= hcnt + DW'(1);
        end
        TAIL: begin
          if (half_end) begin
            hcnt <= '0;
            cs_n <= 1'b1;
            gcnt <= '0;
            st   <= GAP;
            if (second) begin
              rsp_done    <= 1'b1;
              rsp_data    <= OUT_W'($signed(rx_sr[23:8]));
              rsp_status  <= rx_sr[25:24];
              rsp_crc_err <= ~crc_ok;
              rsp_dev_err <= &rx_sr[25:24];
            end
          end else hcnt <= hcnt + DW'(1);
        end
        GAP: begin
          if (gcnt == GW'(GAP_CYCLES - 1)) begin
            if (!second) begin
              second <= 1'b1;
              tx_sr  <= mk_frame(1'b0, addr_q, 16'h0000);
              cs_n   <= 1'b0;
              hcnt   <= '0;
              bitn   <= '0;
              st     <= SHIFT;
            end else st <= IDLE;
          end else gcnt <= gcnt + GW'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sensor_frame_xcvr_chk.sv
module sensor_frame_xcvr_chk #(
  parameter int GAP   = 1,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [OUT_W-1:0] rsp_data
);
  localparam int CW = $clog2(GAP + 2);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= CW'(GAP);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < CW'(GAP)) hi_cnt <= hi_cnt + CW'(1);
  end

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi));
  p_gap_min_r8:   assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> (hi_cnt >= CW'(GAP)));
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
  p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> !req_ready);
  p_sign_ext_r4:  assert property (@(posedge clk) disable iff (!rst_n)
                    rsp_done |-> (rsp_data[OUT_W-1:15] == '0 || rsp_data[OUT_W-1:15] == '1));
endmodule

bind sensor_frame_xcvr sensor_frame_xcvr_chk #(.GAP(GAP_CYCLES), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data)
);

// File: tb/test_sensor_frame_xcvr.sv
`timescale 1ns/1ps
module test_sensor_frame_xcvr;
  localparam int CLK_HZ = 200_000_000;
  localparam int GAP_US = 10;
  localparam int CLK_DIV = 2;
  localparam int OUT_W = 32;
  localparam int GAP = (CLK_HZ / 1_000_000) * GAP_US;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rsp_done, rsp_crc_err, rsp_dev_err, sclk, mosi, cs_n;
  logic [OUT_W-1:0] rsp_data;
  logic [1:0] rsp_status;
  logic miso = 0;

  always #2.5 clk = ~clk;

  sensor_frame_xcvr #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US), .CLK_DIV(CLK_DIV), .OUT_W(OUT_W)) i_sensor_frame_xcvr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .rsp_crc_err(rsp_crc_err), .rsp_dev_err(rsp_dev_err),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int total = 0, bad = 0, n_done = 0, n_req = 0, idle_viol = 0;
  bit started = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [7:0] c;
    c = 8'hFF;
    for (int b = 2; b >= 0; b--) begin
      c = c ^ d[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] cmd(input bit w, input logic [4:0] a, input logic [15:0] d);
    return {w, a, 2'b00, d, ref_crc({w, a, 2'b00, d})};
  endfunction

  function automatic logic [31:0] reply(input logic [1:0] s, input logic [15:0] d, input bit corrupt);
    logic [23:0] h;
    h = {6'h2B, s, d};
    return {h, ref_crc(h) ^ {7'd0, corrupt}};
  endfunction

  logic [31:0] miso_q[$];
  logic [31:0] mosi_q[$];
  string       tag_q[$];
  logic [35:0] exp_q[$];
  logic [31:0] s_tx, s_rx;

  always @(negedge cs_n) begin
    s_tx = (miso_q.size() > 0) ? miso_q.pop_front() : 32'h0;
    miso = s_tx[31];
  end
  always @(negedge sclk) if (!cs_n) begin
    s_tx = s_tx << 1;
    miso = s_tx[31];
  end
  always @(posedge sclk) if (!cs_n) s_rx = {s_rx[30:0], mosi};
  always @(posedge cs_n) if (started) begin
    if (mosi_q.size() == 0) chk(0, "R3 unexpected frame", {32'h0, s_rx}, 64'h0);
    else begin
      logic [31:0] e;
      string t;
      e = mosi_q.pop_front();
      t = tag_q.pop_front();
      chk(s_rx == e, t, {32'h0, s_rx}, {32'h0, e});
    end
  end

  int hi_cnt = 0;
  bit had_frame = 0, prev_done = 0;
  always @(negedge clk) if (started) begin
    if (cs_n && sclk) idle_viol++;
    if (cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && had_frame) chk(hi_cnt >= GAP, "R8 chip-select gap", 64'(hi_cnt), 64'(GAP));
      if (hi_cnt > 0) had_frame = 1;
      hi_cnt = 0;
    end
    if (rsp_done && prev_done) chk(0, "R9 done longer than one cycle", 64'd2, 64'd1);
    if (rsp_done) begin
      n_done++;
      chk(!req_ready, "R9 ready low at done", {63'd0, req_ready}, 64'd0);
      if (exp_q.size() == 0) chk(0, "R9 extra done", 64'd1, 64'd0);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        chk(rsp_data == e[31:0], "R4 payload", {32'h0, rsp_data}, {32'h0, e[31:0]});
        chk(rsp_status == e[33:32], "R5 status", {62'd0, rsp_status}, {62'd0, e[33:32]});
        chk(rsp_dev_err == e[34], "R5 device error", {63'd0, rsp_dev_err}, {63'd0, e[34]});
        chk(rsp_crc_err == e[35], "R6 checksum error", {63'd0, rsp_crc_err}, {63'd0, e[35]});
      end
    end
    prev_done = rsp_done;
  end

  task automatic do_req(input bit w, input logic [4:0] a, input logic [15:0] d,
                        input logic [1:0] st, input logic [15:0] rd, input bit corrupt,
                        input logic [31:0] lit0);
    logic [31:0] f0, good;
    f0 = cmd(w, a, w ? d : 16'h0);
    if (lit0 != 32'h0) f0 = lit0;
    mosi_q.push_back(f0);                 tag_q.push_back("R1 R2 first frame");
    mosi_q.push_back(cmd(1'b0, a, 16'h0)); tag_q.push_back("R3 second frame");
    good = reply(st, rd, corrupt);
    miso_q.push_back(reply(~st | 2'b11, ~rd, !corrupt));
    miso_q.push_back(good);
    exp_q.push_back({corrupt, st == 2'b11, st, {{16{rd[15]}}, rd}});
    n_req++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 16'h0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R10 cs_n at reset", {63'd0, cs_n}, 64'd1);
    chk(sclk == 1'b0, "R10 sclk at reset", {63'd0, sclk}, 64'd0);
    chk(rsp_done == 1'b0, "R10 done at reset", {63'd0, rsp_done}, 64'd0);
    rst_n = 1;
    started = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(cs_n == 1'b1, "R10 cs_n idle after reset", {63'd0, cs_n}, 64'd1);

    do_req(1'b0, 5'd6,  16'h0000, 2'd1, 16'h1234, 1'b0, 32'h180000E5);
    do_req(1'b1, 5'd13, 16'h0020, 2'd0, 16'h0000, 1'b0, 32'hB4002098);
    do_req(1'b1, 5'd13, 16'h0000, 2'd0, 16'h0001, 1'b0, 32'hB400001F);
    do_req(1'b0, 5'd1,  16'hFFFF, 2'd2, 16'h8001, 1'b0, 32'h0);
    do_req(1'b0, 5'd2,  16'h0000, 2'd3, 16'h00FF, 1'b0, 32'h0);
    do_req(1'b0, 5'd3,  16'h0000, 2'd1, 16'h4321, 1'b1, 32'h0);
    do_req(1'b0, 5'd5,  16'h0000, 2'd3, 16'hFF00, 1'b1, 32'h0);
    do_req(1'b0, 5'd31, 16'h0000, 2'd0, 16'h7FFF, 1'b0, 32'h0);
    do_req(1'b1, 5'd0,  16'hFFFF, 2'd1, 16'h8000, 1'b0, 32'h0);
    do_req(1'b1, 5'd12, 16'h001F, 2'd2, 16'hFFFF, 1'b0, 32'h0);

    while (exp_q.size() > 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_done == n_req, "R9 one done per request", 64'(n_done), 64'(n_req));
    chk(mosi_q.size() == 0, "R3 two frames per request", 64'(mosi_q.size()), 64'd0);
    chk(idle_viol == 0, "R7 sclk low while deselected", 64'(idle_viol), 64'd0);
    finish_run();
  end
endmodule